// File: doc/BRIEF.md
# Programmable Serial Frame Master

This block is the master side of a synchronous serial link. It builds each transfer from a timing template. The template has four parts in sequence: a lead-in of idle clocks, a short run of filler clocks, the data bits, and a short run of trailing filler clocks. The block generates the serial clock, the data output line and a frame-sync strobe, and it captures the return line. The frame-sync strobe is placed by its own counters. Its delay is counted in half serial periods from the start of the transfer and its width in whole periods, so it can sit anywhere inside the transfer.

The serial clock is the system clock divided by a fixed even ratio. A one-cycle start strobe latches the transmit word and every timing field. It begins a transfer only if the template satisfies the frame-timing rules. Otherwise the block pulses an error flag and stays idle. When the trailing filler has finished, the received word appears with a one-cycle done pulse.

Top module: `sfm_master`

## Requirements
- R1: The clock mode field selects the sclk behaviour. Mode 0 drives on the falling edge, samples on the rising edge and idles low. Mode 1 drives on rising, samples on falling and idles low. Mode 2 drives on rising, samples on falling and idles high. Mode 3 drives on falling, samples on rising and idles high. While idle, sclk sits at the idle level of the mode currently applied at the input.
- R2: A transfer of N = lead + pre + bits + post serial periods shows exactly 2N sclk transitions. sclk does not move outside a transfer.
- R3: The data phase lasts `cfg_bits_i` periods (4 to 32), one bit per period. It sends the transmit word's low `cfg_bits_i` bits, most significant first, and ends with bit 0.
- R4: The data phase follows `cfg_lead_i` lead-in periods (0 to 7) and then `cfg_pre_i` filler periods (0 to 3). `txd_o` is low during both.
- R5: With h = 2·(period index) + (1 in the second half of a period), the frame strobe is active exactly while `cfg_fs_dly_i` ≤ h < `cfg_fs_dly_i` + 2·`cfg_fs_wid_i`.
- R6: When `cfg_fs_high_i` = 1 the strobe is active-high. When it is 0 the strobe is active-low. Outside the active window the strobe sits at its inactive level.
- R7: During the `cfg_post_i` trailing periods (0 to 3) and after the transfer, `txd_o` is low if `cfg_hold_last_i` = 0. If it is 1, `txd_o` carries bit 0 of the transmit word.
- R8: `rx_i` is captured on the sample edge of each data period only. The captured bits are shifted in MSB first, so `rx_word_o` holds them right-aligned with zeros above.
- R9: `done_o` pulses for exactly one system clock after the last trailing period ends. The block is then idle, and it never raises done and error in the same cycle.
- R10: A start is rejected with a one-cycle `err_o` pulse, and no clock activity follows, if any of these holds: bits is outside 4..32, width is outside 1..44, or delay exceeds 88. It is also rejected if delay + 2·width > 2·N, if width ≥ pre + bits + post, or if delay + 2·width < 2·lead + 2.
- R11: A start strobe during a transfer is ignored. The running transfer keeps its word and template.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a transfer |
| tx_word_i | input | 32 | Word to send, right-aligned |
| cfg_mode_i | input | 2 | Clock mode (edges and idle level) |
| cfg_fs_high_i | input | 1 | Frame strobe active level, 1 = high |
| cfg_hold_last_i | input | 1 | Idle data level: 0 = low, 1 = bit 0 |
| cfg_lead_i | input | 3 | Lead-in periods, 0 to 7 |
| cfg_pre_i | input | 2 | Filler periods before data, 0 to 3 |
| cfg_bits_i | input | 6 | Data bits per transfer, 4 to 32 |
| cfg_post_i | input | 2 | Filler periods after data, 0 to 3 |
| cfg_fs_dly_i | input | 7 | Frame strobe delay in half periods, 0 to 88 |
| cfg_fs_wid_i | input | 6 | Frame strobe width in periods, 1 to 44 |
| rx_i | input | 1 | Serial receive line |
| sclk_o | output | 1 | Serial clock |
| fsync_o | output | 1 | Frame strobe |
| txd_o | output | 1 | Serial transmit line |
| rx_word_o | output | 32 | Received word, right-aligned |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| err_o | output | 1 | One-cycle pulse on a rejected start |

## Verification
The hardest situation to reach from the ports is a start strobe that arrives mid-transfer with a different word, because the port gives no busy indication to aim at. The bench acts as the serial slave and counts sample edges. It raises start with a changed word and bit count right after the fourth sample edge, then checks that every later data bit and the received word still match the original request. The frame-timing boundary cases are reached directly. One template fills the longest transfer with the latest legal strobe, so the strobe ends exactly on the last half period. Further templates each break exactly one timing inequality.

// File: rtl/sfm_pkg.sv
package sfm_pkg;

  localparam int unsigned LEAD_MAX   = 7;
  localparam int unsigned FILL_MAX   = 3;
  localparam int unsigned BITS_MIN   = 4;
  localparam int unsigned FS_DLY_MAX = 88;
  localparam int unsigned FS_WID_MAX = 44;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_st_e;

  // Fields held for the whole transfer
  typedef struct packed {
    logic [1:0] mode;
    logic       fs_high;
    logic       hold_last;
    logic [6:0] fs_dly;
    logic [5:0] fs_wid;
  } tmpl_t;

endpackage

// File: rtl/sfm_cfg_check.sv
module sfm_cfg_check #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned BITS_W = 6
) (
  input  logic [2:0]        lead_i,
  input  logic [1:0]        pre_i,
  input  logic [BITS_W-1:0] bits_i,
  input  logic [1:0]        post_i,
  input  logic [6:0]        fs_dly_i,
  input  logic [5:0]        fs_wid_i,
  output logic              ok_o
);
  import sfm_pkg::*;

  int span_p;
  int fs_end_h;
  int body_p;
  logic range_ok;
  logic timing_ok;

  always_comb begin
    span_p   = int'(lead_i) + int'(pre_i) + int'(bits_i) + int'(post_i);
    body_p   = int'(pre_i) + int'(bits_i) + int'(post_i);
    fs_end_h = int'(fs_dly_i) + 2 * int'(fs_wid_i);

    range_ok = (int'(bits_i) >= int'(BITS_MIN)) && (int'(bits_i) <= int'(WORD_W)) &&
               (int'(fs_dly_i) <= int'(FS_DLY_MAX)) &&
               (int'(fs_wid_i) >= 1) && (int'(fs_wid_i) <= int'(FS_WID_MAX));

    // strobe must close inside the transfer, be shorter than the body,
    // and reach beyond the lead-in by at least one period
    timing_ok = (fs_end_h <= 2 * span_p) &&
                (int'(fs_wid_i) < body_p) &&
                (fs_end_h >= 2 * int'(lead_i) + 2);

    ok_o = range_ok && timing_ok;
  end

endmodule

// File: rtl/sfm_clkdiv.sv
module sfm_clkdiv #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || (cnt_q == LAST)) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = run_i && (cnt_q == LAST);

  generate
    if (HALF_DIV > 1) begin : g_gap_chk
      // R2: half periods last HALF_DIV system clocks, never one
      p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/sfm_frame.sv
module sfm_frame #(
  parameter int unsigned PER_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [PER_W:0]   half_idx_i,
  input  logic [PER_W-1:0] total_i,
  input  logic [6:0]       dly_i,
  input  logic [5:0]       wid_i,
  input  logic             fs_high_i,
  output logic             fsync_o
);
  logic act;
  int   win_end;

  always_comb begin
    win_end = int'(dly_i) + 2 * int'(wid_i);
    act     = run_i && (int'(half_idx_i) >= int'(dly_i)) && (int'(half_idx_i) < win_end);
    fsync_o = fs_high_i ? act : !act;
  end

  // R5: an accepted template never lets the strobe outlive the transfer
  p_fs_in_xfer_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act |-> (int'(half_idx_i) < 2 * int'(total_i)));

endmodule

// File: rtl/sfm_master.sv
module sfm_master #(
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned HALF_DIV = 2,
  parameter int unsigned BITS_W   = $clog2(WORD_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic [1:0]        cfg_mode_i,
  input  logic              cfg_fs_high_i,
  input  logic              cfg_hold_last_i,
  input  logic [2:0]        cfg_lead_i,
  input  logic [1:0]        cfg_pre_i,
  input  logic [BITS_W-1:0] cfg_bits_i,
  input  logic [1:0]        cfg_post_i,
  input  logic [6:0]        cfg_fs_dly_i,
  input  logic [5:0]        cfg_fs_wid_i,
  input  logic              rx_i,
  output logic              sclk_o,
  output logic              fsync_o,
  output logic              txd_o,
  output logic [WORD_W-1:0] rx_word_o,
  output logic              done_o,
  output logic              err_o
);
  import sfm_pkg::*;

  localparam int unsigned PER_MAX = LEAD_MAX + 2 * FILL_MAX + WORD_W;
  localparam int unsigned PER_W   = $clog2(PER_MAX + 1);

  seq_st_e           st_q, st_d;
  logic [PER_W-1:0]  per_q, per_d;
  logic              half_q, half_d;
  logic [WORD_W-1:0] tx_sh_q, tx_sh_d;
  logic [WORD_W-1:0] rx_sh_q, rx_sh_d;
  tmpl_t             tmpl_q, tmpl_d;
  logic [PER_W-1:0]  ds_q, ds_d;
  logic [PER_W-1:0]  de_q, de_d;
  logic [PER_W-1:0]  tot_q, tot_d;
  logic              last_q, last_d;
  logic              done_q, done_d;
  logic              err_q, err_d;

  logic cfg_ok;
  logic tick;
  logic run;
  logic in_data;
  logic lead_lvl;
  logic end_val;

  sfm_cfg_check #(
    .WORD_W (WORD_W),
    .BITS_W (BITS_W)
  ) u_check (
    .lead_i   (cfg_lead_i),
    .pre_i    (cfg_pre_i),
    .bits_i   (cfg_bits_i),
    .post_i   (cfg_post_i),
    .fs_dly_i (cfg_fs_dly_i),
    .fs_wid_i (cfg_fs_wid_i),
    .ok_o     (cfg_ok)
  );

  assign run = (st_q == ST_RUN);

  sfm_clkdiv #(
    .HALF_DIV (HALF_DIV)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  sfm_frame #(
    .PER_W (PER_W)
  ) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .half_idx_i ({per_q, half_q}),
    .total_i    (tot_q),
    .dly_i      (tmpl_q.fs_dly),
    .wid_i      (tmpl_q.fs_wid),
    .fs_high_i  (tmpl_q.fs_high),
    .fsync_o    (fsync_o)
  );

  assign in_data = (per_q >= ds_q) && (per_q < de_q);

  // next-state logic
  always_comb begin
    st_d    = st_q;
    per_d   = per_q;
    half_d  = half_q;
    tx_sh_d = tx_sh_q;
    rx_sh_d = rx_sh_q;
    tmpl_d  = tmpl_q;
    ds_d    = ds_q;
    de_d    = de_q;
    tot_d   = tot_q;
    last_d  = last_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          if (cfg_ok) begin
            st_d             = ST_RUN;
            per_d            = '0;
            half_d           = 1'b0;
            tmpl_d.mode      = cfg_mode_i;
            tmpl_d.fs_high   = cfg_fs_high_i;
            tmpl_d.hold_last = cfg_hold_last_i;
            tmpl_d.fs_dly    = cfg_fs_dly_i;
            tmpl_d.fs_wid    = cfg_fs_wid_i;
            ds_d             = PER_W'(cfg_lead_i) + PER_W'(cfg_pre_i);
            de_d             = PER_W'(cfg_lead_i) + PER_W'(cfg_pre_i) + PER_W'(cfg_bits_i);
            tot_d            = PER_W'(cfg_lead_i) + PER_W'(cfg_pre_i) +
                               PER_W'(cfg_bits_i) + PER_W'(cfg_post_i);
            tx_sh_d          = tx_word_i << (WORD_W - int'(cfg_bits_i));
            rx_sh_d          = '0;
            last_d           = tx_word_i[0];
          end else begin
            err_d = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (tick) begin
          if (!half_q) begin
            half_d = 1'b1;
            if (in_data) begin
              rx_sh_d = {rx_sh_q[WORD_W-2:0], rx_i};
            end
          end else begin
            half_d = 1'b0;
            if (in_data) begin
              tx_sh_d = tx_sh_q << 1;
            end
            if (per_q == tot_q - PER_W'(1)) begin
              st_d   = ST_IDLE;
              per_d  = '0;
              done_d = 1'b1;
            end else begin
              per_d = per_q + PER_W'(1);
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      per_q   <= '0;
      half_q  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
      tmpl_q  <= '0;
      ds_q    <= '0;
      de_q    <= '0;
      tot_q   <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      per_q   <= per_d;
      half_q  <= half_d;
      tx_sh_q <= tx_sh_d;
      rx_sh_q <= rx_sh_d;
      tmpl_q  <= tmpl_d;
      ds_q    <= ds_d;
      de_q    <= de_d;
      tot_q   <= tot_d;
      last_q  <= last_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  // line outputs
  always_comb begin
    lead_lvl = tmpl_q.mode[0] ^ tmpl_q.mode[1];
    end_val  = tmpl_q.hold_last & last_q;
    if (run) begin
      sclk_o = half_q ? !lead_lvl : lead_lvl;
      if (in_data) begin
        txd_o = tx_sh_q[WORD_W-1];
      end else if (per_q < ds_q) begin
        txd_o = 1'b0;
      end else begin
        txd_o = end_val;
      end
    end else begin
      sclk_o = cfg_mode_i[1];
      txd_o  = end_val;
    end
  end

  assign rx_word_o = rx_sh_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

  // R9: done is a single-cycle pulse
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9: done and error are exclusive
  p_done_err_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));

  // R10: a rejected start leaves the sequencer idle
  p_reject_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (st_q == ST_IDLE));

  // R11: a start during a transfer does not touch the held template
  p_busy_ignore_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && start_i) |=> ($stable(tmpl_q) && $stable(tot_q)));

  // R3: the data line moves only on a half-period boundary
  p_txd_steady_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !tick) |=> $stable(txd_o));

  // R2: the serial clock moves only on a half-period boundary
  p_sclk_steady_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !tick) |=> $stable(sclk_o));

endmodule

// File: tb/sfm_master_tb.sv
module sfm_master_tb_top;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [31:0] tx_word_i;
  logic [1:0]  cfg_mode_i;
  logic        cfg_fs_high_i;
  logic        cfg_hold_last_i;
  logic [2:0]  cfg_lead_i;
  logic [1:0]  cfg_pre_i;
  logic [5:0]  cfg_bits_i;
  logic [1:0]  cfg_post_i;
  logic [6:0]  cfg_fs_dly_i;
  logic [5:0]  cfg_fs_wid_i;
  logic        rx_i;
  logic        sclk_o;
  logic        fsync_o;
  logic        txd_o;
  logic [31:0] rx_word_o;
  logic        done_o;
  logic        err_o;

  int checks;
  int errors;

  sfm_master #(
    .WORD_W   (32),
    .HALF_DIV (2)
  ) dut_i (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .start_i         (start_i),
    .tx_word_i       (tx_word_i),
    .cfg_mode_i      (cfg_mode_i),
    .cfg_fs_high_i   (cfg_fs_high_i),
    .cfg_hold_last_i (cfg_hold_last_i),
    .cfg_lead_i      (cfg_lead_i),
    .cfg_pre_i       (cfg_pre_i),
    .cfg_bits_i      (cfg_bits_i),
    .cfg_post_i      (cfg_post_i),
    .cfg_fs_dly_i    (cfg_fs_dly_i),
    .cfg_fs_wid_i    (cfg_fs_wid_i),
    .rx_i            (rx_i),
    .sclk_o          (sclk_o),
    .fsync_o         (fsync_o),
    .txd_o           (txd_o),
    .rx_word_o       (rx_word_o),
    .done_o          (done_o),
    .err_o           (err_o)
  );

  initial clk = 1'b0;
  always #2 clk = !clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int mode, input bit fsh, input bit hold, input int lead,
                         input int pre, input int bits, input int post, input int dly,
                         input int wid);
    cfg_mode_i      = 2'(mode);
    cfg_fs_high_i   = fsh;
    cfg_hold_last_i = hold;
    cfg_lead_i      = 3'(lead);
    cfg_pre_i       = 2'(pre);
    cfg_bits_i      = 6'(bits);
    cfg_post_i      = 2'(post);
    cfg_fs_dly_i    = 7'(dly);
    cfg_fs_wid_i    = 6'(wid);
  endtask

  // receive line value for period k: data bits MSB first, 1 elsewhere
  function automatic bit rx_of(input int k, input int ds, input int bits, input logic [31:0] w);
    if (k >= ds && k < ds + bits) return w[bits - 1 - (k - ds)];
    return 1'b1;
  endfunction

  task automatic run_xfer(input int mode, input bit fsh, input bit hold, input int lead,
                          input int pre, input int bits, input int post, input int dly,
                          input int wid, input logic [31:0] txw, input logic [31:0] rxw,
                          input bit poke);
    int ds, de, n, k, edges, cyc, bad_data, bad_pre, bad_post, bad_fs;
    bit prev, sample_lvl, got_done, poked, exp_tx, act_fs, end_v;
    longint mask;
    ds = lead + pre;
    de = ds + bits;
    n  = de + post;
    end_v = hold ? txw[0] : 1'b0;
    sample_lvl = (mode == 0) || (mode == 3);
    mask = (64'h1 << bits) - 1;
    @(negedge clk);
    set_cfg(mode, fsh, hold, lead, pre, bits, post, dly, wid);
    tx_word_i = txw;
    rx_i = rx_of(0, ds, bits, rxw);
    @(negedge clk);
    chk(sclk_o == mode[1], "R1", "idle level before start", sclk_o, mode[1]);
    prev = sclk_o;
    start_i = 1'b1;
    k = 0; edges = 0; cyc = 0; got_done = 0; poked = 0;
    bad_data = 0; bad_pre = 0; bad_post = 0; bad_fs = 0;
    while (!got_done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (start_i) begin
        start_i = 1'b0;
      end else if (poke && !poked && k == 4) begin
        start_i    = 1'b1;
        tx_word_i  = ~txw;
        cfg_bits_i = 6'd4;
        poked      = 1;
      end
      if (sclk_o != prev) begin
        edges++;
        prev = sclk_o;
        if (sclk_o == sample_lvl) begin
          if (k < ds) exp_tx = 1'b0;
          else if (k < de) exp_tx = txw[bits - 1 - (k - ds)];
          else exp_tx = end_v;
          if (txd_o !== exp_tx) begin
            if (k < ds) bad_pre++;
            else if (k < de) bad_data++;
            else bad_post++;
          end
          act_fs = ((2 * k + 1) >= dly) && ((2 * k + 1) < dly + 2 * wid);
          if (fsync_o !== (fsh ? act_fs : !act_fs)) bad_fs++;
          k++;
          rx_i = rx_of(k, ds, bits, rxw);
        end
      end
      if (done_o) got_done = 1;
    end
    chk(got_done, "R9", "done seen", got_done, 1);
    chk(k == n, "R1", "sample edges in programmed direction", k, n);
    chk(edges == 2 * n, "R2", "sclk transitions", edges, 2 * n);
    if (poke) chk(bad_data == 0, "R11", "data bits after busy start", bad_data, 0);
    else chk(bad_data == 0, "R3", "data bits MSB first", bad_data, 0);
    chk(bad_pre == 0, "R4", "low line in lead-in and filler", bad_pre, 0);
    chk(bad_post == 0, "R7", "trailing filler level", bad_post, 0);
    chk(bad_fs == 0, "R5", "frame strobe window", bad_fs, 0);
    chk(rx_word_o == 32'(rxw & mask), "R8", "received word", rx_word_o, rxw & mask);
    @(negedge clk);
    chk(done_o == 1'b0, "R9", "done single cycle", done_o, 0);
    chk(sclk_o == mode[1], "R1", "idle level after transfer", sclk_o, mode[1]);
    chk(fsync_o == !fsh, "R6", "strobe inactive level", fsync_o, !fsh);
    chk(txd_o == end_v, "R7", "line level after transfer", txd_o, end_v);
  endtask

  task automatic bad_cfg(input int lead, input int pre, input int bits, input int post,
                         input int dly, input int wid, input string why);
    int moved;
    bit prev;
    @(negedge clk);
    set_cfg(1, 1'b1, 1'b0, lead, pre, bits, post, dly, wid);
    tx_word_i = 32'hA5A5_A5A5;
    @(negedge clk);
    prev = sclk_o;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(err_o == 1'b1, "R10", why, err_o, 1);
    moved = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk_o != prev || done_o || err_o) moved++;
    end
    chk(moved == 0, "R10", {why, " no activity"}, moved, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    checks = 0;
    errors = 0;
    rst_n = 1'b0;
    start_i = 1'b0;
    tx_word_i = '0;
    rx_i = 1'b0;
    set_cfg(0, 1'b1, 1'b0, 0, 0, 8, 0, 0, 1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sclk_o == 1'b0, "R1", "reset sclk", sclk_o, 0);
    chk(txd_o == 1'b0, "R7", "reset txd", txd_o, 0);
    chk(done_o == 1'b0, "R9", "reset done", done_o, 0);
    chk(err_o == 1'b0, "R10", "reset err", err_o, 0);
    chk(rx_word_o == 32'h0, "R8", "reset rx word", rx_word_o, 0);

    run_xfer(0, 1'b1, 1'b0, 2, 1, 8, 1, 3, 4, 32'h0000_00B6, 32'h0000_005A, 1'b0);
    run_xfer(1, 1'b0, 1'b1, 0, 0, 4, 0, 0, 1, 32'h0000_000B, 32'h0000_0006, 1'b0);
    run_xfer(2, 1'b1, 1'b0, 7, 3, 32, 3, 88, 1, 32'hC3A5_96E1, 32'h8F0F_3C71, 1'b0);
    run_xfer(3, 1'b0, 1'b1, 1, 2, 16, 2, 5, 10, 32'h0000_9E37, 32'h0000_6B2D, 1'b0);

    bad_cfg(0, 0, 3, 0, 0, 1, "bits below minimum");
    bad_cfg(0, 0, 8, 0, 0, 0, "zero strobe width");
    bad_cfg(0, 0, 4, 0, 7, 1, "strobe past end");
    bad_cfg(3, 0, 8, 0, 0, 1, "strobe before first edge");
    bad_cfg(2, 0, 4, 0, 0, 4, "width not below body");

    run_xfer(0, 1'b1, 1'b1, 1, 0, 12, 1, 2, 6, 32'h0000_0A5D, 32'h0000_0C93, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule